// File: doc/BRIEF.md
# Physical-to-Virtual Synonym Tracker

This block sits between the address translator and a direct-mapped data cache that is indexed and tagged with virtual addresses. For each physical cache line that the cache holds, it records which virtual line index the line lives at. It keeps at most one virtual alias per physical line. When a miss brings a physical line into the cache under a new virtual index, the block is told the (physical, virtual) pair. It then returns the virtual line index that the cache must evict, if there is one. When a coherence snoop names a physical line, the block looks it up and returns the virtual line index to invalidate.

The table has 64 sets of 8 ways. The set is picked by physical address bits [11:6] and the tag is bits [35:12]. Because a virtual and a physical address share their page offset, an entry stores only virtual bits [14:12]. A full 9-bit virtual line index is rebuilt as {stored bits, set}. Inserts take two cycles and are accepted at most every other cycle. Snoop lookups flow at one per clock. All evictions leave through one valid/ready output.

Top module: `syn_rlut`

## Requirements
- R1: A synchronous active-high reset empties the table. After reset, `inv_valid` is low, `ins_ready` and `snp_ready` are high, and no snoop finds an entry.
- R2: Address ports carry physical line addresses. Port bit k is physical bit k+6, so port bits [5:0] select the set and port bits [29:6] form the tag. The invalidate index is {virtual bits [14:12], port bits [5:0]}: `inv_vline[8:6]` holds the stored virtual bits and `inv_vline[5:0]` holds the set.
- R3: An insert whose tag is absent while the set has an empty way stores the pair in the lowest-numbered empty way and emits no invalidate.
- R4: An insert whose tag is present overwrites that entry's virtual bits. It emits the old index when the old bits differ from the new ones and nothing when they match. A tag never occupies two ways.
- R5: An insert whose tag is absent from a full set replaces the way named by that set's round-robin pointer and emits the displaced entry's index. The pointer is 0 after reset and advances by one, wrapping, only on such a replacement.
- R6: A snoop that hits emits the stored index and empties that way in the same operation. A snoop that misses emits nothing.
- R7: While `inv_valid` is low and no insert is offered, `snp_ready` is high, so snoops are accepted one per clock.
- R8: In the cycle after an insert is accepted, `ins_ready` is low.
- R9: While `inv_ready` is low, `inv_valid` and `inv_vline` hold. A request that needs an invalidate waits in the lookup stage and lowers both request readies. No invalidate is lost or reordered.
- R10: When an insert and a snoop are offered in the same cycle, the insert is taken and `snp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert request offered |
| ins_ready | output | 1 | Insert request accepted this cycle when high |
| ins_la | input | 30 | Physical line address of the insert (physical bits [35:6]) |
| ins_vx | input | 3 | Virtual address bits [14:12] of the insert |
| snp_valid | input | 1 | Snoop lookup offered |
| snp_ready | output | 1 | Snoop lookup accepted this cycle when high |
| snp_la | input | 30 | Physical line address of the snoop |
| inv_valid | output | 1 | Invalidate request pending |
| inv_ready | input | 1 | Cache takes the invalidate this cycle |
| inv_vline | output | 9 | Virtual line index to invalidate |

## Verification
Each set receives one entry and is then snooped twice. The first snoop must return {vx, set}; the second must return nothing. A wrong set or tag slice, or a hit that leaves the way valid, shows up as a wrong or a repeated invalidate. One set is filled, overflowed, partly emptied by snoops, refilled and overflowed again. Picking the wrong way, reusing a non-empty way or moving the pointer on a fill into an empty way each change the sequence of evicted indices. A tag is inserted twice with different virtual bits and then with the same bits. A duplicated entry shows up as a second snoop hit, and a needless eviction as an extra invalidate. Back-to-back snoops, a stalled invalidate output, colliding insert and snoop requests, and a mid-run reset check for lost handshakes, dropped outputs and the insert gap.

// File: rtl/syn_rlut.sv
module syn_rlut #(
  parameter int LA_W = 30,
  parameter int SET_W = 6,
  parameter int VX_W = 3,
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ins_valid,
  output logic                    ins_ready,
  input  logic [LA_W-1:0]         ins_la,
  input  logic [VX_W-1:0]         ins_vx,
  input  logic                    snp_valid,
  output logic                    snp_ready,
  input  logic [LA_W-1:0]         snp_la,
  output logic                    inv_valid,
  input  logic                    inv_ready,
  output logic [VX_W+SET_W-1:0]   inv_vline
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = LA_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int VL_W  = VX_W + SET_W;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [VX_W-1:0]  vx_q  [SETS][WAYS];
  logic [WAYS-1:0]  val_q [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic             s_v, s_ins;
  logic [TAG_W-1:0] s_tag;
  logic [SET_W-1:0] s_set;
  logic [VX_W-1:0]  s_vx;

  logic [WAYS-1:0]  hit_vec, free_vec;
  logic [WAY_W-1:0] hit_way, free_way, wr_way;
  logic [VX_W-1:0]  old_vx;
  logic [LA_W-1:0]  in_la;
  logic s_hit, any_free, need, adv, ins_fire, snp_fire;

  always_comb begin
    free_vec = ~val_q[s_set];
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = val_q[s_set][w] && (tag_q[s_set][w] == s_tag);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end

  assign s_hit    = |hit_vec;
  assign any_free = |free_vec;
  assign wr_way   = s_hit ? hit_way : (any_free ? free_way : rr_q[s_set]);
  assign old_vx   = vx_q[s_set][wr_way];
  assign need     = s_v && (s_ins ? (s_hit ? (old_vx != s_vx) : !any_free) : s_hit);
  assign adv      = !need || !inv_valid || inv_ready;

  assign ins_ready = adv && !(s_v && s_ins);
  assign ins_fire  = ins_valid && ins_ready;
  assign snp_ready = adv && !ins_fire;
  assign snp_fire  = snp_valid && snp_ready;
  assign in_la     = ins_fire ? ins_la : snp_la;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v   <= 1'b0;
      s_ins <= 1'b0;
    end else if (adv) begin
      s_v   <= ins_fire || snp_fire;
      s_ins <= ins_fire;
      s_tag <= in_la[LA_W-1:SET_W];
      s_set <= in_la[SET_W-1:0];
      s_vx  <= ins_vx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) begin
        val_q[i] <= '0;
        rr_q[i]  <= '0;
      end
    end else if (s_v && adv) begin
      if (s_ins) begin
        val_q[s_set][wr_way] <= 1'b1;
        if (!s_hit && !any_free)
          rr_q[s_set] <= (rr_q[s_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[s_set] + WAY_W'(1);
      end else if (s_hit) begin
        val_q[s_set][hit_way] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (s_v && adv && s_ins) begin
      tag_q[s_set][wr_way] <= s_tag;
      vx_q[s_set][wr_way]  <= s_vx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_valid <= 1'b0;
    end else begin
      if (inv_ready) inv_valid <= 1'b0;
      if (need && adv) begin
        inv_valid <= 1'b1;
        inv_vline <= VL_W'({old_vx, s_set});
      end
    end
  end
endmodule

// File: rtl/syn_rlut_chk.sv
module syn_rlut_chk #(
  parameter int VL_W = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            ins_valid,
  input logic            ins_ready,
  input logic            snp_valid,
  input logic            snp_ready,
  input logic            inv_valid,
  input logic            inv_ready,
  input logic [VL_W-1:0] inv_vline
);
  logic take;
  assign take = (ins_valid && ins_ready) || (snp_valid && snp_ready);

  p_inv_hold_r9: assert property (@(posedge clk) disable iff (rst)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_vline));

  p_ins_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_ready |=> !ins_ready);

  p_ins_first_r10: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_ready |-> !(snp_valid && snp_ready));

  p_snp_rate_r7: assert property (@(posedge clk) disable iff (rst)
    !inv_valid && !ins_valid |-> snp_ready);

  p_inv_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(inv_valid) |-> $past(take, 2));
endmodule

bind syn_rlut syn_rlut_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst(rst),
  .ins_valid(ins_valid), .ins_ready(ins_ready),
  .snp_valid(snp_valid), .snp_ready(snp_ready),
  .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_vline(inv_vline)
);

// File: tb/tb_syn_rlut.sv
module tb_syn_rlut;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, snp_valid = 1'b0, inv_ready = 1'b1;
  logic [29:0] ins_la = '0, snp_la = '0;
  logic [2:0]  ins_vx = '0;
  logic ins_ready, snp_ready, inv_valid;
  logic [8:0] inv_vline;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int log_v [0:1023];
  int log_n = 0, rd = 0;

  syn_rlut dut (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_la(ins_la), .ins_vx(ins_vx),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_la(snp_la),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_vline(inv_vline)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk)
    if (!rst && inv_valid && inv_ready && log_n < 1024) begin
      log_v[log_n] = int'(inv_vline);
      log_n++;
    end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [29:0] la(int t, int s);
    return {t[23:0], s[5:0]};
  endfunction

  function automatic int vl(int vx, int s);
    return vx * 64 + s;
  endfunction

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic exp_inv(string r, int e);
    if (rd < log_n) begin
      chk(r, log_v[rd], e);
      rd++;
    end else chk(r, -1, e);
  endtask

  task automatic exp_none(string r);
    chk(r, log_n - rd, 0);
    rd = log_n;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic ins(logic [29:0] a, int vx);
    @(posedge clk); #1;
    ins_valid = 1'b1; ins_la = a; ins_vx = vx[2:0];
    do @(negedge clk); while (!ins_ready);
    @(posedge clk); #1;
    ins_valid = 1'b0;
    settle();
  endtask

  task automatic snp(logic [29:0] a);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_la = a;
    do @(negedge clk); while (!snp_ready);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 inv_valid after reset", int'(inv_valid), 0);
    chk("R1 ins_ready after reset", int'(ins_ready), 1);
    chk("R1 snp_ready after reset", int'(snp_ready), 1);
    snp(la(7, 3));
    exp_none("R1 empty table snoop");

    // R2 R3 R6: one entry per set, snoop twice
    for (int s = 0; s < 64; s++) ins(la(s * 3 + 1, s), s % 8);
    exp_none("R3 inserts into empty sets");
    for (int s = 0; s < 64; s++) begin
      snp(la(s * 3 + 1, s));
      exp_inv("R2 R6 snoop hit index", vl(s % 8, s));
      snp(la(s * 3 + 1, s));
      exp_none("R6 second snoop after clear");
    end

    // R3 R5: fill and overflow set 5
    for (int i = 0; i < 8; i++) ins(la(100 + i, 5), i);
    exp_none("R3 fill set 5");
    ins(la(200, 5), 7);
    exp_inv("R5 first displacement way0", vl(0, 5));
    ins(la(201, 5), 6);
    exp_inv("R5 second displacement way1", vl(1, 5));
    snp(la(100, 5));
    exp_none("R5 displaced tag gone");
    snp(la(102, 5));
    exp_inv("R6 snoop way2", vl(2, 5));
    snp(la(200, 5));
    exp_inv("R6 snoop way0", vl(7, 5));
    ins(la(300, 5), 3);
    ins(la(301, 5), 5);
    exp_none("R3 refill empty ways");
    ins(la(302, 5), 1);
    exp_inv("R5 pointer unmoved by empty fills", vl(5, 5));
    ins(la(303, 5), 0);
    exp_inv("R5 pointer advances", vl(3, 5));

    // R4: same tag re-insert
    ins(la(50, 9), 3);
    exp_none("R4 first insert");
    ins(la(50, 9), 5);
    exp_inv("R4 replace old alias", vl(3, 9));
    ins(la(50, 9), 5);
    exp_none("R4 same bits no invalidate");
    snp(la(50, 9));
    exp_inv("R4 single entry hit", vl(5, 9));
    snp(la(50, 9));
    exp_none("R4 no duplicate entry");

    // R7: back-to-back snoops
    for (int k = 0; k < 4; k++) ins(la(2, 30 + k), k + 1);
    exp_none("R7 setup");
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_la = la(2, 30);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk("R7 snoop ready each cycle", int'(snp_ready), 1);
      @(posedge clk); #1;
      snp_la = la(2, 30 + k);
    end
    @(negedge clk);
    chk("R7 snoop ready last", int'(snp_ready), 1);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    settle();
    for (int k = 0; k < 4; k++) exp_inv("R7 pipelined result", vl(k + 1, 30 + k));

    // R8 R10: insert gap and priority
    @(posedge clk); #1;
    ins_valid = 1'b1; ins_la = la(9, 40); ins_vx = 3'd6;
    snp_valid = 1'b1; snp_la = la(9, 42);
    @(negedge clk);
    chk("R10 insert taken", int'(ins_ready), 1);
    chk("R10 snoop held", int'(snp_ready), 0);
    @(posedge clk); #1;
    ins_la = la(9, 41); ins_vx = 3'd2;
    @(negedge clk);
    chk("R8 insert gap", int'(ins_ready), 0);
    chk("R8 snoop during insert write", int'(snp_ready), 1);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk);
    chk("R8 insert ready again", int'(ins_ready), 1);
    @(posedge clk); #1;
    ins_valid = 1'b0;
    settle();
    exp_none("R10 snoop miss and inserts");
    snp(la(9, 40));
    exp_inv("R10 first insert stored", vl(6, 40));
    snp(la(9, 41));
    exp_inv("R8 second insert stored", vl(2, 41));

    // R9: output backpressure
    ins(la(1, 20), 2);
    ins(la(1, 21), 4);
    exp_none("R9 setup");
    inv_ready = 1'b0;
    snp(la(1, 20));
    @(negedge clk);
    chk("R9 valid while stalled", int'(inv_valid), 1);
    chk("R9 data while stalled", int'(inv_vline), vl(2, 20));
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_la = la(1, 21);
    @(negedge clk);
    chk("R9 stage accepts", int'(snp_ready), 1);
    @(posedge clk); #1;
    snp_la = la(77, 22);
    repeat (3) begin
      @(negedge clk);
      chk("R9 snoop ready low in stall", int'(snp_ready), 0);
      chk("R9 insert ready low in stall", int'(ins_ready), 0);
      chk("R9 data held", int'(inv_vline), vl(2, 20));
    end
    @(posedge clk); #1;
    inv_ready = 1'b1;
    do @(negedge clk); while (!snp_ready);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    settle();
    exp_inv("R9 first after stall", vl(2, 20));
    exp_inv("R9 second after stall", vl(4, 21));
    exp_none("R9 miss after stall");

    // R1: reset mid-run
    ins(la(11, 60), 5);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    snp(la(11, 60));
    exp_none("R1 reset clears entry");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule